// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Sequencer

This block produces the high-side and low-side gate-drive enables for two interleaved buck phases. A shared counter forms a fixed switching period of `PERIOD` ticks. Each phase's cycle opens when its high-side switch is forced off. The second phase opens half a period after the first. After that turn-off the low-side switch is held on for a fixed share of the period. The high-side switch is then armed and fires when that phase's digitised ramp-versus-error compare flag is seen. A short dead interval separates the low-side turn-off from the high-side turn-on.

Each phase also emits a one-tick strobe in the middle of its forced low-side interval. A current sampler placed next to the block can use it. An enable input and a drive-kill input both stop all switching at once. When running is allowed again, each phase stays fully off until its own next cycle start.

Top module: `pwm2_interleave_seq`

## Requirements
- R1: While `rst_i` is high, and on the first tick after it, every drive and strobe output is low.
- R2: Phase 0 opens its cycle on the first running edge and then every `PERIOD` (48) ticks. At that point its high-side output goes low and its low-side output goes high.
- R3: Phase 1 opens its cycles `PERIOD/2` (24) ticks after phase 0 opens.
- R4: After a cycle opens, the low-side output stays high for at least `PERIOD/3` (16) ticks. Compare flags seen at the first 15 edges of the cycle (local positions 1..15) are ignored.
- R5: A compare flag seen at local position 16 or later, while the low side is on, drops the low side on the next tick. The high side rises `DEAD` (2) ticks after that.
- R6: For either phase, the high-side and low-side outputs are never high in the same tick.
- R7: Once high, a high-side output stays high until its phase's next cycle start, or until running stops.
- R8: If no compare flag is seen in a cycle, the high side stays low and the low side stays high for the whole cycle.
- R9: `isample_o[p]` pulses for exactly one tick per cycle, at local position `PERIOD/6` (8) + 1, and only while that phase's low side is on.
- R10: If `kill_i` is high or `en_i` is low at an edge, all drive and strobe outputs are low on the following tick and the timebase returns to position 0.
- R11: Once running resumes, phase 0 opens at once. Phase 1 keeps both drive outputs low until its own first cycle start, half a period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timebase tick clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Sequencing enable |
| kill_i | input | 1 | Forces all drives off while high |
| cmp_i | input | 2 | Per-phase flag: ramp has crossed the error level |
| hi_drv_o | output | 2 | Per-phase high-side switch enable |
| lo_drv_o | output | 2 | Per-phase low-side switch enable |
| isample_o | output | 2 | Per-phase current-sample strobe |

## Verification
The assertions place no rule on the compare flags, the enable or the kill input. Any pattern on any tick is legal, so they must hold under fully arbitrary inputs. The one fact they rely on is that `DEAD` is at least 1, so a high-side rise always follows a tick with the low side off. The stimulus therefore uses independent random compare flags at several densities, plus sections with the flags held high and held low. Kill and enable are toggled at random, which places stops at every position in the period, including during the dead interval.

// File: rtl/pwm2_seq_pkg.sv
package pwm2_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_DEAD = 2'd2,
    PH_HIGH = 2'd3
  } ph_state_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PERIOD = 48,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          run_i,
  output logic [CW-1:0] pos_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i)                pos_o <= '0;
    else if (pos_o == CW'(PERIOD - 1))  pos_o <= '0;
    else                                pos_o <= pos_o + 1'b1;
  end
endmodule

// File: rtl/pwm_phase_seq.sv
module pwm_phase_seq
  import pwm2_seq_pkg::*;
#(
  parameter int PERIOD = 48,
  parameter int OFFSET = 0,
  parameter int FORCED = 16,
  parameter int DEAD   = 2,
  parameter int SAMPLE = 8,
  localparam int CW = $clog2(PERIOD),
  localparam int DW = $clog2(DEAD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          run_i,
  input  logic [CW-1:0] pos_i,
  input  logic          cmp_i,
  output logic          hi_o,
  output logic          lo_o,
  output logic          smp_o
);
  logic [CW-1:0] lpos;
  ph_state_t     st_q, st_n;
  logic [DW-1:0] dcnt_q, dcnt_n;

  // position of the shared counter relative to this phase's cycle start
  always_comb begin
    if (pos_i >= CW'(OFFSET)) lpos = pos_i - CW'(OFFSET);
    else                      lpos = pos_i + CW'(PERIOD - OFFSET);
  end

  always_comb begin
    st_n   = st_q;
    dcnt_n = dcnt_q;
    if (lpos == '0) begin
      st_n = PH_LOW;
    end else begin
      case (st_q)
        PH_LOW: begin
          if (lpos >= CW'(FORCED) && cmp_i) begin
            st_n   = PH_DEAD;
            dcnt_n = DW'(DEAD - 1);
          end
        end
        PH_DEAD: begin
          if (dcnt_q == '0) st_n = PH_HIGH;
          else              dcnt_n = dcnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      st_q   <= PH_IDLE;
      dcnt_q <= '0;
      hi_o   <= 1'b0;
      lo_o   <= 1'b0;
      smp_o  <= 1'b0;
    end else begin
      st_q   <= st_n;
      dcnt_q <= dcnt_n;
      hi_o   <= (st_n == PH_HIGH);
      lo_o   <= (st_n == PH_LOW);
      smp_o  <= (st_q == PH_LOW) && (lpos == CW'(SAMPLE));
    end
  end
endmodule

// File: rtl/pwm2_interleave_seq.sv
module pwm2_interleave_seq #(
  parameter int PERIOD  = 48,
  parameter int DEAD    = 2,
  parameter int N_PHASE = 2
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               en_i,
  input  logic               kill_i,
  input  logic [N_PHASE-1:0] cmp_i,
  output logic [N_PHASE-1:0] hi_drv_o,
  output logic [N_PHASE-1:0] lo_drv_o,
  output logic [N_PHASE-1:0] isample_o
);
  localparam int CW     = $clog2(PERIOD);
  localparam int FORCED = PERIOD / 3;
  localparam int SAMPLE = FORCED / 2;

  logic          run;
  logic [CW-1:0] pos;

  assign run = en_i && !kill_i;

  pwm_timebase #(.PERIOD(PERIOD)) u_tb (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .run_i (run),
    .pos_o (pos)
  );

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    pwm_phase_seq #(
      .PERIOD (PERIOD),
      .OFFSET ((p * PERIOD) / N_PHASE),
      .FORCED (FORCED),
      .DEAD   (DEAD),
      .SAMPLE (SAMPLE)
    ) u_ph (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .run_i (run),
      .pos_i (pos),
      .cmp_i (cmp_i[p]),
      .hi_o  (hi_drv_o[p]),
      .lo_o  (lo_drv_o[p]),
      .smp_o (isample_o[p])
    );
  end
endmodule

// File: rtl/pwm2_interleave_chk.sv
module pwm2_interleave_chk #(
  parameter int N_PHASE = 2
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               en_i,
  input logic               kill_i,
  input logic [N_PHASE-1:0] hi_drv_o,
  input logic [N_PHASE-1:0] lo_drv_o,
  input logic [N_PHASE-1:0] isample_o
);
  for (genvar p = 0; p < N_PHASE; p++) begin : g_chk
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (rst_i)
      !(hi_drv_o[p] && lo_drv_o[p])); // R6
    AST_STOP_ALL_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
      (kill_i || !en_i) |=> (!hi_drv_o[p] && !lo_drv_o[p] && !isample_o[p])); // R10
    AST_STROBE_IN_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      isample_o[p] |-> lo_drv_o[p]); // R9
    AST_RISE_AFTER_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(hi_drv_o[p]) |-> $past(!lo_drv_o[p])); // R5
    AST_FALL_TO_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      ($fell(hi_drv_o[p]) && $past(en_i && !kill_i)) |-> lo_drv_o[p]); // R7
  end
endmodule

bind pwm2_interleave_seq pwm2_interleave_chk #(.N_PHASE(N_PHASE)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .en_i      (en_i),
  .kill_i    (kill_i),
  .hi_drv_o  (hi_drv_o),
  .lo_drv_o  (lo_drv_o),
  .isample_o (isample_o)
);

// File: tb/pwm2_interleave_seq_tb.sv
module pwm2_interleave_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 48;
  localparam int D    = 2;
  localparam int OFF  = P / 3;
  localparam int SMP  = OFF / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       kill = 1'b0;
  logic [1:0] cmp = 2'b00;
  logic [1:0] hi, lo, smp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state: 0 idle, 1 low-on, 2 gap, 3 high-on
  int m_cnt = 0;
  int m_st[2] = '{0, 0};
  int m_dc[2] = '{0, 0};
  bit m_smp[2] = '{0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm2_interleave_seq #(.PERIOD(P), .DEAD(D), .N_PHASE(2)) dut_i (
    .clk_i (clk), .rst_i (rst), .en_i (en), .kill_i (kill), .cmp_i (cmp),
    .hi_drv_o (hi), .lo_drv_o (lo), .isample_o (smp)
  );

  function automatic int local_pos(int cnt, int ph);
    return (cnt - ph * (P / 2) + P) % P;
  endfunction

  always @(posedge clk) begin
    if (rst || !en || kill) begin
      m_cnt = 0;
      for (int p = 0; p < 2; p++) begin m_st[p] = 0; m_dc[p] = 0; m_smp[p] = 0; end
    end else begin
      for (int p = 0; p < 2; p++) begin
        int lp;
        lp = local_pos(m_cnt, p);
        m_smp[p] = (m_st[p] == 1) && (lp == SMP);
        if (lp == 0) m_st[p] = 1;
        else if (m_st[p] == 1 && lp >= OFF && cmp[p]) begin m_st[p] = 2; m_dc[p] = D - 1; end
        else if (m_st[p] == 2) begin
          if (m_dc[p] == 0) m_st[p] = 3; else m_dc[p]--;
        end
      end
      m_cnt = (m_cnt + 1) % P;
    end
  end

  task automatic check_bit(string t, string what, int p, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s phase %0d %s: actual %b expected %b at %0t", t, p, what, got, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int p = 0; p < 2; p++) begin
      check_bit(tag, "high-side", p, hi[p], m_st[p] == 3);
      check_bit(tag, "low-side", p, lo[p], m_st[p] == 1);
      check_bit(tag, "strobe", p, smp[p], m_smp[p]);
      check_bit("R6", "overlap", p, hi[p] & lo[p], 1'b0);
    end
  endtask

  task automatic run_ticks(int n, int dens, int killpct, int offpct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      cmp[0] = ($urandom % 100) < dens;
      cmp[1] = ($urandom % 100) < dens;
      kill = ($urandom % 100) < killpct;
      en = !(($urandom % 100) < offpct);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    tag = "R1";
    for (int i = 0; i < 4; i++) begin @(negedge clk); check_all(); end
    rst = 1'b0; en = 1'b1;
    tag = "R2";  run_ticks(150, 50, 0, 0);
    tag = "R4";  run_ticks(150, 100, 0, 0);  // flags always high: earliest turn-on
    tag = "R3";  run_ticks(200, 30, 0, 0);
    tag = "R5";  run_ticks(200, 8, 0, 0);
    tag = "R8";  run_ticks(150, 0, 0, 0);    // no crossing at all
    tag = "R7";  run_ticks(200, 15, 0, 0);
    tag = "R9";  run_ticks(200, 40, 0, 0);
    // directed stop in the middle of a high-side interval
    tag = "R10";
    run_ticks(40, 100, 0, 0);
    @(negedge clk); check_all(); kill = 1'b1;
    run_ticks(3, 100, 100, 0);
    tag = "R11";
    @(negedge clk); check_all(); kill = 1'b0; en = 1'b1;
    run_ticks(60, 100, 0, 0);
    tag = "R10"; run_ticks(400, 40, 3, 0);
    tag = "R11"; run_ticks(400, 40, 0, 3);
    tag = "R1";
    @(negedge clk); check_all(); rst = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); check_all(); end
    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end
endmodule